// File: doc/BRIEF.md
# Dual-Mode Fixed-Point Multiplier

This block multiplies two signed 16-bit operands and captures the 32-bit result in a product register one clock after a start strobe. A single mode input, sampled together with the operands, decides how the result is aligned. With the mode input high, the operands are plain two's-complement integers and the full product is stored exactly as the multiplier produces it. With the mode input low, the operands are read as 1.15 fractions. In this encoding 0x4000 is one half, 0x2000 is one quarter, 0x8000 is minus one and 0x7FFF is the largest value below plus one. The raw product of two such values carries a duplicated sign bit (2.30 form), so the block shifts it left by one place and stores it in 1.31 form.

The upper 16 bits of the stored product are also driven on a port of their own. In a fixed-point datapath, this word is normally the one passed to the next operation, which keeps word lengths from growing. The product register keeps its value until the next strobe, and a one-cycle valid pulse marks each new result. Accumulation, guard bits, rounding and saturation are not part of this block. The one overflow case in fractional mode, minus one times minus one, wraps.

Top module: `fxmul_dual`

## Requirements
- R1: A synchronous reset clears the product register, so the product and high word read zero, and it holds the valid output low.
- R2: With the mode input at 1 (integer), the stored product is the exact signed 32-bit product of the two operands with no shift; for example, 0x0010 times 0x0010 gives 0x00000100.
- R3: With the mode input at 0 (fractional), the stored product is the signed product shifted left by one bit, truncated to 32 bits, and bit 0 is zero; for example, 0x0010 times 0x0010 gives 0x00000200.
- R4: In fractional mode, 0x0002 times 0x4000 (one half) stores 0x00010000, so the high word reads 0x0001.
- R5: 0x8000 times 0x8000 stores 0x80000000 in fractional mode (a wrap, not saturation) and 0x40000000 in integer mode.
- R6: The high-word output always equals bits 31 to 16 of the product output.
- R7: The valid output is high for exactly the one cycle after each clock edge that samples the start strobe high, and low in every other cycle; the new product appears in that same cycle.
- R8: While the start strobe is low, the product and high word keep their values whatever the operands and mode input do.
- R9: The mode is captured along with the operands at the strobe, so back-to-back operations on the same operands in different modes each follow their own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| go_i | input | 1 | Start strobe: capture a product at this edge |
| opa_i | input | 16 | First operand, two's complement |
| opb_i | input | 16 | Second operand, two's complement |
| int_mode_i | input | 1 | 1 = integer (unshifted), 0 = fractional 1.15 (shift left one) |
| prod_o | output | 32 | Product register |
| prod_hi_o | output | 16 | Upper 16 bits of the product register |
| vld_o | output | 1 | One-cycle pulse marking a new product |

## Verification
The hardest case to reach is a mode change between two operations that run back to back. The mode input has to change at the same edge that captures the next operands, and the result must still follow the mode of its own strobe. The stimulus reaches it by driving the same operands on consecutive cycles with the strobe held high and the mode flipped, and the minus-one squared case is issued this way in both modes. Hold behaviour is checked by changing the operands and the mode for several idle cycles while the product port is watched for any change.

// File: rtl/fxmul_pkg.sv
package fxmul_pkg;

  typedef enum logic {
    MODE_FRAC = 1'b0,
    MODE_INT  = 1'b1
  } mul_mode_e;

  // Left shift applied in fractional mode to drop the duplicated sign bit.
  localparam int FRAC_SHIFT = 1;

endpackage

// File: rtl/fxmul_mult.sv
module fxmul_mult #(
  parameter int OP_W = 16
) (
  input  logic [OP_W-1:0]   opa,
  input  logic [OP_W-1:0]   opb,
  output logic [2*OP_W-1:0] raw
);
  localparam int PROD_W = 2 * OP_W;

  function automatic logic [PROD_W-1:0] signed_mul(
    input logic [OP_W-1:0] a,
    input logic [OP_W-1:0] b
  );
    logic signed [PROD_W-1:0] wa;
    logic signed [PROD_W-1:0] wb;
    wa = PROD_W'($signed(a));
    wb = PROD_W'($signed(b));
    return PROD_W'(wa * wb);
  endfunction

  assign raw = signed_mul(opa, opb);

endmodule

// File: rtl/fxmul_align.sv
module fxmul_align
  import fxmul_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic [2*OP_W-1:0] raw,
  input  logic              int_mode,
  output logic [2*OP_W-1:0] aligned
);
  localparam int PROD_W = 2 * OP_W;

  function automatic logic [PROD_W-1:0] align_prod(
    input logic [PROD_W-1:0] p,
    input mul_mode_e         m
  );
    logic [PROD_W-1:0] r;
    if (m == MODE_INT) r = p;
    else               r = p << FRAC_SHIFT;
    return r;
  endfunction

  mul_mode_e mode_sel;
  assign mode_sel = mul_mode_e'(int_mode);
  assign aligned  = align_prod(raw, mode_sel);

endmodule

// File: rtl/fxmul_preg.sv
module fxmul_preg #(
  parameter int OP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [2*OP_W-1:0] d,
  output logic [2*OP_W-1:0] q,
  output logic [OP_W-1:0]   q_hi,
  output logic              vld
);
  localparam int PROD_W = 2 * OP_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      vld <= 1'b0;
    end else begin
      vld <= load;
      if (load) q <= d;
    end
  end

  assign q_hi = q[PROD_W-1:OP_W];

endmodule

// File: rtl/fxmul_dual.sv
module fxmul_dual #(
  parameter int OP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              go_i,
  input  logic [OP_W-1:0]   opa_i,
  input  logic [OP_W-1:0]   opb_i,
  input  logic              int_mode_i,
  output logic [2*OP_W-1:0] prod_o,
  output logic [OP_W-1:0]   prod_hi_o,
  output logic              vld_o
);
  localparam int PROD_W = 2 * OP_W;

  // Named internal events for the checker.
  logic [PROD_W-1:0] raw_w;
  logic [PROD_W-1:0] aligned_w;
  logic              load_w;

  assign load_w = go_i;

  fxmul_mult #(.OP_W(OP_W)) mult_i (
    .opa (opa_i),
    .opb (opb_i),
    .raw (raw_w)
  );

  fxmul_align #(.OP_W(OP_W)) align_i (
    .raw      (raw_w),
    .int_mode (int_mode_i),
    .aligned  (aligned_w)
  );

  fxmul_preg #(.OP_W(OP_W)) preg_i (
    .clk  (clk_i),
    .rst  (rst_i),
    .load (load_w),
    .d    (aligned_w),
    .q    (prod_o),
    .q_hi (prod_hi_o),
    .vld  (vld_o)
  );

endmodule

// File: rtl/fxmul_dual_chk.sv
module fxmul_dual_chk #(
  parameter int OP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              go,
  input logic [OP_W-1:0]   opa,
  input logic [OP_W-1:0]   opb,
  input logic              int_mode,
  input logic [2*OP_W-1:0] prod,
  input logic              vld
);
  localparam int PROD_W = 2 * OP_W;
  localparam logic [OP_W-1:0]   MIN_OP   = OP_W'(1) << (OP_W-1);
  localparam logic [PROD_W-1:0] MIN_PROD = PROD_W'(1) << (PROD_W-1);

  logic signed [PROD_W-1:0] spec_full;
  logic                     rst_q = 1'b0;

  assign spec_full = PROD_W'(PROD_W'($signed(opa)) * PROD_W'($signed(opb)));

  always @(posedge clk) begin
    if (rst_q) begin
      AST_RESET_CLEAR: assert (prod == '0 && !vld); // R1
    end
    rst_q <= rst;
  end

  AST_INT_UNSHIFTED: assert property (@(posedge clk) disable iff (rst)
    (go && int_mode) |=> prod == $past(spec_full)); // R2

  AST_FRAC_SHIFTED: assert property (@(posedge clk) disable iff (rst)
    (go && !int_mode) |=> (prod == ($past(spec_full) << 1)) && !prod[0]); // R3

  AST_FRAC_MIN_WRAP: assert property (@(posedge clk) disable iff (rst)
    (go && !int_mode && opa == MIN_OP && opb == MIN_OP) |=> prod == MIN_PROD); // R5

  AST_VLD_AFTER_GO: assert property (@(posedge clk) disable iff (rst)
    go |=> vld); // R7

  AST_NO_GO_NO_VLD: assert property (@(posedge clk) disable iff (rst)
    !go |=> !vld); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !go |=> $stable(prod)); // R8

endmodule

bind fxmul_dual fxmul_dual_chk #(.OP_W(OP_W)) chk_i (
  .clk      (clk_i),
  .rst      (rst_i),
  .go       (go_i),
  .opa      (opa_i),
  .opb      (opb_i),
  .int_mode (int_mode_i),
  .prod     (prod_o),
  .vld      (vld_o)
);

// File: tb/fxmul_dual_tb_top.sv
`timescale 1ns/1ps
module fxmul_dual_tb_top;
  localparam int OP_W   = 16;
  localparam int PROD_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              go  = 1'b0;
  logic [OP_W-1:0]   opa = '0;
  logic [OP_W-1:0]   opb = '0;
  logic              int_mode = 1'b0;
  logic [PROD_W-1:0] prod;
  logic [OP_W-1:0]   prod_hi;
  logic              vld;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  typedef struct {
    logic [PROD_W-1:0] val;
    string             tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  fxmul_dual #(.OP_W(OP_W)) dut_i (
    .clk_i      (clk),
    .rst_i      (rst),
    .go_i       (go),
    .opa_i      (opa),
    .opb_i      (opb),
    .int_mode_i (int_mode),
    .prod_o     (prod),
    .prod_hi_o  (prod_hi),
    .vld_o      (vld)
  );

  // Reference: wide signed multiply, doubled in fractional mode, kept to 32 bits.
  function automatic logic [PROD_W-1:0] ref_prod(input logic [OP_W-1:0] a,
                                                  input logic [OP_W-1:0] b,
                                                  input logic im);
    longint pa, pb, p;
    pa = longint'($signed(a));
    pb = longint'($signed(b));
    p  = pa * pb;
    if (!im) p = p * 2;
    return p[PROD_W-1:0];
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [PROD_W-1:0] act, input logic [PROD_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: issue one operation and push its expected result.
  task automatic op(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b,
                    input logic im, input string tag);
    exp_t e;
    @(negedge clk);
    opa = a; opb = b; int_mode = im; go = 1'b1;
    e.val = ref_prod(a, b, im);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      go = 1'b0;
    end
  endtask

  // Monitor: sample 2 ns after each rising edge.
  always @(posedge clk) begin
    #2;
    if (!rst && vld) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R7 unexpected valid", {31'b0, vld}, '0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(prod === e.val, e.tag, prod, e.val);
        check(prod_hi === prod[PROD_W-1:OP_W], "R6 high word",
              {16'b0, prod_hi}, {16'b0, prod[PROD_W-1:OP_W]});
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    logic [PROD_W-1:0] held;
    logic [15:0]       lf;
    repeat (3) @(posedge clk);
    #2;
    check(prod === '0 && prod_hi === '0 && vld === 1'b0, "R1 reset state",
          prod, '0);
    @(negedge clk); rst = 1'b0;

    // R2 integer mode
    op(16'h0010, 16'h0010, 1'b1, "R2 int 0x10*0x10");
    op(16'hFFFF, 16'h0003, 1'b1, "R2 int -1*3");
    op(16'h7FFF, 16'h7FFF, 1'b1, "R2 int max*max");
    idle(2);
    // R3 fractional mode
    op(16'h0010, 16'h0010, 1'b0, "R3 frac 0x10*0x10");
    op(16'h4000, 16'h4000, 1'b0, "R3 frac half*half");
    op(16'h8000, 16'h4000, 1'b0, "R3 frac -1*half");
    idle(1);
    // R4 high word holds the scaled result
    op(16'h0002, 16'h4000, 1'b0, "R4 frac 2*half");
    idle(2);
    check(prod === 32'h0001_0000 && prod_hi === 16'h0001, "R4 high word 0x0001",
          prod, 32'h0001_0000);
    // R5 and R9: minus one squared, mode flipped back to back
    op(16'h8000, 16'h8000, 1'b0, "R5 frac -1*-1 wraps");
    op(16'h8000, 16'h8000, 1'b1, "R5 int -1*-1");
    op(16'h0010, 16'h0010, 1'b1, "R9 mode int after frac");
    op(16'h0010, 16'h0010, 1'b0, "R9 mode frac after int");
    idle(2);

    // R8 hold: change inputs without a strobe
    held = prod;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      opa = 16'h1234 + 16'(i); opb = 16'h7F00 - 16'(i); int_mode = i[0];
      @(posedge clk); #2;
      check(prod === held && prod_hi === held[31:16], "R8 hold while idle",
            prod, held);
      check(vld === 1'b0, "R7 no valid without strobe", {31'b0, vld}, '0);
    end

    // R1 mid-run reset
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    check(prod === '0 && vld === 1'b0, "R1 reset clears product", prod, '0);
    @(negedge clk); rst = 1'b0;

    // Mixed pattern sweep
    lf = 16'hACE1;
    for (int i = 0; i < 24; i++) begin
      logic [15:0] a, b;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      a = lf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      b = lf ^ 16'h5A5A;
      op(a, b, i[0], i[0] ? "R2 int sweep" : "R3 frac sweep");
      if (i % 5 == 4) idle(1);
    end
    idle(3);
    check(sb_q.size() == 0, "R7 every strobe produced valid",
          32'(sb_q.size()), '0);
    summary();
  end

endmodule